// File: doc/BRIEF.md
# Shift-Register Synchronous FIFO

This block is a small first-in first-out buffer for a single clock domain. Each data bit has its own 16-place shift register, and all the bit slices shift together. A word that is written always lands in place 0, and every word already held moves one place further in. Reading never moves any data. A single up/down occupancy counter selects which place of the shift registers drives the read port. Because the counter always points at the oldest word held, the read data is simply the entry at that tap. The read data is combinational from the stored entries and the count.

The counter is one bit wider than the tap address and resets to all ones. With that encoding, "empty" is the counter's top bit. A control state machine tracks the fill condition with three states. EMPTY is the reset state. HOLDING means one to fifteen words are held. FULL means sixteen words are held. The state machine has these transitions:
- EMPTY to HOLDING on an accepted push.
- HOLDING to FULL on a push with no pop, when the count is 14.
- HOLDING to EMPTY on a pop with no push, when the count is 0.
- FULL to HOLDING on a pop with no push.

Every other case holds the state. From the accepted push and pop, each cycle decodes one of four operations: IDLE, INC, DEC or SWAP. SWAP shifts the storage while leaving the count alone.

Top module: `srfifo_top`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `empty` is 1 and `full` is 0.
- R2: Words pushed while not full are read back in the order they were written, with every bit of the word preserved.
- R3: A pop while not empty removes the oldest word. The next oldest word then appears on `rd_data` after the same edge. Popping the last word sets `empty`.
- R4: A push and a pop in the same cycle, while neither empty nor full, keep the occupancy unchanged. `rd_data` then shows the word that followed the popped one.
- R5: `full` is 1 exactly when 16 words are held.
- R6: A push while full without a pop is ignored: the contents and `rd_data` are unchanged. A push together with a pop while full is accepted as a swap.
- R7: A pop while empty is ignored. The count never wraps below its all-ones empty value. A push together with a pop while empty stores the pushed word.
- R8: `empty` is 1 exactly when no words are held, and `empty` and `full` are never both 1.
- R9: Reset clears the occupancy in the middle of traffic. A push presented during the reset cycle is not counted.
- R10: `rd_data` equals the oldest held word whenever `empty` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all storage and control |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store on an accepted push |
| pop | input | 1 | Read-and-remove request |
| rd_data | output | WIDTH | Oldest held word (combinational from storage and count) |
| empty | output | 1 | No words held |
| full | output | 1 | Sixteen words held |

## Verification
The bench goes after the boundaries: pushing into a full buffer, popping from an empty one, and push-with-pop at every occupancy from 0 to 16.
- A design that accepted a push while full would shift the oldest word out of the last tap, and the read order would break.
- A counter that wrapped on a pop while empty would report a full buffer of stale data.
- A swap that also moved the count would make `rd_data` skip a word or repeat one.

A mid-traffic reset carrying a push checks that the reset wins. Random traffic against a queue model checks the order of words of all bit patterns.

// File: rtl/srfifo_pkg.sv
package srfifo_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_HOLDING = 2'd1,
        ST_FULL    = 2'd2
    } fill_state_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2,
        OP_SWAP = 2'd3
    } occ_op_t;

endpackage

// File: rtl/srfifo_slice.sv
// One bit lane: fixed insertion at place 0, addressable tap on the read side.
module srfifo_slice #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          shift_en,
    input  logic          din,
    input  logic [AW-1:0] tap_sel,
    output logic          dout
);

    logic [DEPTH-1:0] lane_q;

    // Storage carries no reset: contents are only meaningful under the count.
    always_ff @(posedge clk) begin
        if (shift_en) begin
            lane_q <= {lane_q[DEPTH-2:0], din};
        end
    end

    assign dout = lane_q[tap_sel];

endmodule

// File: rtl/srfifo_ctrl.sv
// Occupancy counter plus fill-state machine. The count resets to all ones.
module srfifo_ctrl
    import srfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    output logic          shift_en,
    output logic [CW-1:0] occ_cnt,
    output logic [AW-1:0] tap_sel,
    output logic          empty,
    output logic          full
);

    localparam logic [CW-1:0] CNT_EMPTY = {CW{1'b1}};
    localparam logic [CW-1:0] CNT_TOP   = CW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_PRE   = CW'(DEPTH - 2);
    localparam logic [CW-1:0] CNT_ONE   = CW'(1);

    fill_state_t state_q, state_d;
    occ_op_t     op;
    logic [CW-1:0] cnt_q, cnt_d;
    logic push_ok, pop_ok;

    // Acceptance: a push into FULL only goes through when paired with a pop.
    always_comb begin
        pop_ok  = pop  && (state_q != ST_EMPTY);
        push_ok = push && ((state_q != ST_FULL) || pop);
        unique case ({push_ok, pop_ok})
            2'b11:   op = OP_SWAP;
            2'b10:   op = OP_INC;
            2'b01:   op = OP_DEC;
            default: op = OP_IDLE;
        endcase
    end

    // Single-level count update: hold, +1 or -1.
    always_comb begin
        unique case (op)
            OP_INC:  cnt_d = cnt_q + CNT_ONE;
            OP_DEC:  cnt_d = cnt_q - CNT_ONE;
            default: cnt_d = cnt_q;
        endcase
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (op == OP_INC) state_d = ST_HOLDING;
            end
            ST_HOLDING: begin
                if (op == OP_INC && cnt_q == CNT_PRE)
                    state_d = ST_FULL;
                else if (op == OP_DEC && cnt_q == '0)
                    state_d = ST_EMPTY;
            end
            ST_FULL: begin
                if (op == OP_DEC) state_d = ST_HOLDING;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // State and count registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
            cnt_q   <= CNT_EMPTY;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs.
    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (state_q)
            ST_EMPTY: empty = 1'b1;
            ST_FULL:  full  = 1'b1;
            default: ;
        endcase
        shift_en = push_ok;
        occ_cnt  = cnt_q;
        tap_sel  = cnt_q[AW-1:0];
    end

    // Keep CNT_TOP referenced for readability of the full encoding.
    logic unused_top;
    assign unused_top = ^CNT_TOP;

endmodule

// File: rtl/srfifo_top.sv
module srfifo_top #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic          shift_en;
    logic [CW-1:0] occ_cnt;
    logic [AW-1:0] tap_sel;

    srfifo_ctrl #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .CW    (CW)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .shift_en (shift_en),
        .occ_cnt  (occ_cnt),
        .tap_sel  (tap_sel),
        .empty    (empty),
        .full     (full)
    );

    for (genvar b = 0; b < WIDTH; b++) begin : g_lane
        srfifo_slice #(
            .DEPTH (DEPTH),
            .AW    (AW)
        ) u_slice (
            .clk      (clk),
            .shift_en (shift_en),
            .din      (wr_data[b]),
            .tap_sel  (tap_sel),
            .dout     (rd_data[b])
        );
    end

endmodule

// File: rtl/srfifo_checker.sv
module srfifo_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          push,
    input logic          pop,
    input logic          empty,
    input logic          full,
    input logic [CW-1:0] occ_cnt
);

    p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    p_empty_is_msb_r8: assert property (@(posedge clk) disable iff (rst)
        empty == occ_cnt[CW-1]);

    p_no_underwrap_r7: assert property (@(posedge clk) disable iff (rst)
        occ_cnt[CW-1] |-> (&occ_cnt));

    p_pop_empty_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> (empty && $stable(occ_cnt)));

    p_push_full_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (full && $stable(occ_cnt)));

    p_swap_keeps_count_r4: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !empty) |=> $stable(occ_cnt));

    p_last_pop_empties_r3: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !empty && occ_cnt == '0) |=> empty);

    p_full_at_top_r5: assert property (@(posedge clk) disable iff (rst)
        full == (occ_cnt == CW'(DEPTH - 1)));

endmodule

bind srfifo_top srfifo_checker #(
    .DEPTH (DEPTH),
    .CW    (CW)
) u_checker (
    .clk     (clk),
    .rst     (rst),
    .push    (push),
    .pop     (pop),
    .empty   (empty),
    .full    (full),
    .occ_cnt (occ_cnt)
);

// File: tb/test_srfifo_top.sv
module test_srfifo_top;

    localparam int W = 8;
    localparam int D = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         push;
    logic [W-1:0] wr_data;
    logic         pop;
    logic [W-1:0] rd_data;
    logic         empty;
    logic         full;

    int checks   = 0;
    int failures = 0;
    logic [W-1:0] q[$];

    always #10 clk = ~clk;

    srfifo_top #(.WIDTH(W), .DEPTH(D)) i_srfifo_top (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .wr_data (wr_data),
        .pop     (pop),
        .rd_data (rd_data),
        .empty   (empty),
        .full    (full)
    );

    task automatic check_bit(input string tag, input string what,
                             input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check_bit(tag, "empty", int'(empty), int'(q.size() == 0));
        check_bit(tag, "full", int'(full), int'(q.size() == D));
        if (q.size() > 0) check_bit(tag, "rd_data", int'(rd_data), int'(q[0]));
    endtask

    // Drive at the falling edge, update the model after the rising edge, then compare.
    task automatic step(input logic p, input logic o, input logic [W-1:0] d,
                        input string tag);
        bit pop_ok, push_ok;
        @(negedge clk);
        push = p; pop = o; wr_data = d;
        pop_ok  = o && (q.size() > 0);
        push_ok = p && ((q.size() < D) || o);
        @(posedge clk);
        #2;
        if (pop_ok) void'(q.pop_front());
        if (push_ok) q.push_back(d);
        check_all(tag);
    endtask

    task automatic do_reset(input logic p);
        @(negedge clk);
        rst = 1'b1; push = p; pop = 1'b0; wr_data = 8'hA5;
        @(posedge clk);
        #2;
        q.delete();
        @(negedge clk);
        rst = 1'b0; push = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; push = 1'b0; pop = 1'b0; wr_data = '0;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check_all("R1");
        @(negedge clk);
        rst = 1'b0;

        // R7: pops while empty, and push+pop while empty stores the word
        step(1'b0, 1'b1, 8'h00, "R7");
        step(1'b0, 1'b1, 8'h00, "R7");
        step(1'b1, 1'b1, 8'h3C, "R7");
        step(1'b0, 1'b1, 8'h00, "R3");

        // R2/R5: fill to 16 with patterns covering every bit
        for (int i = 0; i < D; i++)
            step(1'b1, 1'b0, 8'((i * 37 + 5) ^ (i[0] ? 8'hFF : 8'h00)), "R2_R5");
        // R6: push while full is ignored
        step(1'b1, 1'b0, 8'hEE, "R6");
        step(1'b1, 1'b0, 8'h11, "R6");
        // R6: push with pop while full swaps
        step(1'b1, 1'b1, 8'h77, "R6");
        // R3/R8: drain completely, then one more pop
        for (int i = 0; i < D + 2; i++)
            step(1'b0, 1'b1, 8'h00, "R3_R8");

        // R4: swap at every occupancy 0..16
        for (int n = 0; n <= D; n++) begin
            for (int i = 0; i < n; i++)
                step(1'b1, 1'b0, 8'(n * 16 + i), "R4");
            step(1'b1, 1'b1, 8'(8'hC0 + n), "R4");
            step(1'b1, 1'b1, 8'(8'h80 + n), "R4");
            while (q.size() > 0) step(1'b0, 1'b1, 8'h00, "R4");
        end

        // R9: reset during traffic with a push present
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 8'(8'h50 + i), "R9");
        do_reset(1'b1);
        #2;
        check_all("R9");
        step(1'b0, 1'b1, 8'h00, "R9");
        step(1'b1, 1'b0, 8'h9D, "R9");

        // R10: random traffic against the queue model
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            logic p = (r < 55) || (r >= 85);
            logic o = (r >= 45);
            step(p, o, 8'($urandom), "R10");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule